// File: doc/BRIEF.md
# Keyed-Swap Substitution Round Function

This block is the mixing function of one round of a 64-bit Feistel cipher. It takes one 32-bit half of the data block and a 60-bit round subkey, and returns a 32-bit value that the surrounding round logic XORs into the other half. The half is first widened into four overlapping 10-bit groups. A 20-bit part of the subkey then chooses, bit by bit, whether matching bits are exchanged between two pairs of groups. The remaining 40 subkey bits are XORed in. Each 10-bit group then goes through its own substitution box, which raises a column value to the seventh power in a binary polynomial field. The field and an XOR offset are chosen by the two outer bits of the group. The four 8-bit results are scattered into the 32-bit output by a fixed bit map.

A small controller sequences the work over two register stages. In state IDLE the block waits. A `start` pulse seen in IDLE loads the key-mixed 40-bit value and moves to MIX. MIX always goes on to EMIT, and on that transition the substituted and permuted word is registered. EMIT raises `out_valid` for exactly that one cycle and always returns to IDLE. A `start` seen in MIX or EMIT is dropped. Generating the subkeys is left to the caller.

Top module: `keyswap_round`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_valid` is 0 and `result` is 0 until the first operation completes.
- R2: The input half P is widened into groups G1 = {P[1:0], P[31:24]}, G2 = P[25:16], G3 = P[17:8], G4 = P[9:0] (MSB first). They are packed as the 40-bit word {G1,G2,G3,G4}, with G1 in bits 39:30.
- R3: Swap-key bit j (0..19) acts on group bit b = j/2. When j is odd and the bit is 1, bit b of G1 and bit b of G3 are exchanged. When j is even and the bit is 1, bit b of G2 and bit b of G4 are exchanged. A 0 bit leaves its pair in place.
- R4: The subkey holds the swap key in bits 59:40 and the XOR key in bits 39:0. The XOR key is XORed onto the swapped 40-bit word with the same bit alignment. The swap key never acts as XOR data.
- R5: In each 10-bit box input X, the row is {X[9], X[0]} and the column is C = X[8:1]. The word bits 39:30 feed box 1, and so on down to bits 9:0, which feed box 4.
- R6: Each box output equals (C xor O)^7, computed with carry-less GF(2) polynomial products and reduced by the 9-bit modulus M. O and M depend on box and row (rows 0..3). Offsets: box1 131,133,155,205; box2 204,167,173,65; box3 75,46,212,51; box4 234,205,46,4. Moduli: box1 333,313,505,369; box2 379,375,319,391; box3 361,445,451,397; box4 397,425,395,505.
- R7: The four box outputs form Y = {S1,S2,S3,S4}, with S1 in bits 31:24. Bit i of Y goes to bit (13*i + 7) mod 32 of `result`.
- R8: A `start` sampled in IDLE on clock edge k makes `out_valid` 1 after edge k+1 and 0 again after edge k+2. `result` holds its value from edge k+1 until the next operation completes.
- R9: A `start` sampled on the two edges that follow an accepted one is ignored. It neither changes `result` nor produces a further `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin one round computation |
| half_in | input | 32 | Data half to be mixed |
| subkey | input | 60 | Round subkey: swap key in bits 59:40, XOR key in bits 39:0 |
| out_valid | output | 1 | One-cycle strobe marking a fresh `result` |
| result | output | 32 | Round function output |

## Verification
A new request can coincide with the presentation of the previous result: `start` may be high on the very edge that moves the controller into EMIT, or on the edge that returns it to IDLE. The bench holds `start` high with different data through both of those edges. It then confirms two things: the word presented is still the first request's result, and no second `out_valid` pulse follows one cycle later. The substitution arithmetic is judged with hand-derived words whose column values are 0, 1 and 2, where the answers are 0, 1 and 0x80 in every field, and with model comparisons across all four rows.

// File: rtl/keyswap_round_pkg.sv
package keyswap_round_pkg;

    localparam int HALF_W    = 32;
    localparam int GRP_W     = 10;
    localparam int NGRP      = 4;
    localparam int SB_W      = 8;
    localparam int NROW      = 4;
    localparam int MOD_W     = SB_W + 1;
    localparam int PKEY_W    = 2 * GRP_W;
    localparam int XKEY_W    = NGRP * GRP_W;
    localparam int SUBKEY_W  = PKEY_W + XKEY_W;
    localparam int PROD_W    = 2 * SB_W - 1;
    localparam int PERM_MUL  = 13;
    localparam int PERM_ADD  = 7;

    localparam logic [SB_W-1:0] SB_OFFSET [NGRP][NROW] = '{
        '{8'd131, 8'd133, 8'd155, 8'd205},
        '{8'd204, 8'd167, 8'd173, 8'd65 },
        '{8'd75,  8'd46,  8'd212, 8'd51 },
        '{8'd234, 8'd205, 8'd46,  8'd4  }
    };

    localparam logic [MOD_W-1:0] SB_MODULUS [NGRP][NROW] = '{
        '{9'd333, 9'd313, 9'd505, 9'd369},
        '{9'd379, 9'd375, 9'd319, 9'd391},
        '{9'd361, 9'd445, 9'd451, 9'd397},
        '{9'd397, 9'd425, 9'd395, 9'd505}
    };

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MIX  = 2'd1,
        ST_EMIT = 2'd2
    } round_state_t;

    // Carry-less product followed by reduction by a degree-8 polynomial.
    function automatic logic [SB_W-1:0] gf_mul(
        input logic [SB_W-1:0]  a,
        input logic [SB_W-1:0]  b,
        input logic [MOD_W-1:0] m
    );
        logic [PROD_W-1:0] p;
        p = '0;
        for (int i = 0; i < SB_W; i++) begin
            if (b[i]) p = p ^ (PROD_W'(a) << i);
        end
        for (int k = PROD_W - 1; k >= SB_W; k--) begin
            if (p[k]) p = p ^ (PROD_W'(m) << (k - SB_W));
        end
        return p[SB_W-1:0];
    endfunction

    // a^7 through the chain a^2, a^3, a^6, a^7.
    function automatic logic [SB_W-1:0] gf_pow7(
        input logic [SB_W-1:0]  a,
        input logic [MOD_W-1:0] m
    );
        logic [SB_W-1:0] a2, a3, a6;
        a2 = gf_mul(a, a, m);
        a3 = gf_mul(a2, a, m);
        a6 = gf_mul(a3, a3, m);
        return gf_mul(a6, a, m);
    endfunction

endpackage

// File: rtl/keyswap_expand_mix.sv
module keyswap_expand_mix
    import keyswap_round_pkg::*;
(
    input  logic [HALF_W-1:0] half_in,
    input  logic [PKEY_W-1:0] swap_key,
    input  logic [XKEY_W-1:0] xor_key,
    output logic [XKEY_W-1:0] mixed
);

    logic [GRP_W-1:0] g1, g2, g3, g4;
    logic [GRP_W-1:0] s1, s2, s3, s4;

    // R2: widening into four overlapping groups is pure wiring
    assign g1 = {half_in[1:0], half_in[31:24]};
    assign g2 = half_in[25:16];
    assign g3 = half_in[17:8];
    assign g4 = half_in[9:0];

    // R3: one 2-to-1 selector pair per group bit and per group pair
    for (genvar b = 0; b < GRP_W; b++) begin : g_swap
        localparam int ODD_J  = 2 * b + 1;
        localparam int EVEN_J = 2 * b;
        assign s1[b] = swap_key[ODD_J]  ? g3[b] : g1[b];
        assign s3[b] = swap_key[ODD_J]  ? g1[b] : g3[b];
        assign s2[b] = swap_key[EVEN_J] ? g4[b] : g2[b];
        assign s4[b] = swap_key[EVEN_J] ? g2[b] : g4[b];
    end

    // R4: XOR key applied with matching alignment
    assign mixed = {s1, s2, s3, s4} ^ xor_key;

    // R3: an exchange never alters the XOR of the two groups of a pair
    always_comb begin
        pair_xor_chk: assert (((s1 ^ s3) == (g1 ^ g3)) && ((s2 ^ s4) == (g2 ^ g4)));
    end

endmodule

// File: rtl/keyswap_sbox.sv
module keyswap_sbox
    import keyswap_round_pkg::*;
#(
    parameter int BOX = 0
) (
    input  logic [GRP_W-1:0] x,
    output logic [SB_W-1:0]  y
);

    logic [1:0]       row;
    logic [SB_W-1:0]  col;
    logic [SB_W-1:0]  base;
    logic [MOD_W-1:0] modulus;

    // R5: outer bits select the row, inner eight bits form the column
    assign row     = {x[GRP_W-1], x[0]};
    assign col     = x[GRP_W-2:1];
    assign base    = col ^ SB_OFFSET[BOX][row];
    assign modulus = SB_MODULUS[BOX][row];

    // R6: seventh power in the row's field
    assign y = gf_pow7(base, modulus);

    // R6
    always_comb begin
        if (base == '0) begin
            zero_base_chk: assert (y == '0);
        end
        if (base == 8'd1) begin
            unit_base_chk: assert (y == 8'd1);
        end
    end

endmodule

// File: rtl/keyswap_out_perm.sv
module keyswap_out_perm
    import keyswap_round_pkg::*;
(
    input  logic [HALF_W-1:0] box_word,
    output logic [HALF_W-1:0] perm_word
);

    // R7: fixed scatter; an odd stride over a power-of-two width is a bijection
    for (genvar i = 0; i < HALF_W; i++) begin : g_map
        localparam int DST = (i * PERM_MUL + PERM_ADD) % HALF_W;
        assign perm_word[DST] = box_word[i];
    end

endmodule

// File: rtl/keyswap_round.sv
module keyswap_round
    import keyswap_round_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [HALF_W-1:0]   half_in,
    input  logic [SUBKEY_W-1:0] subkey,
    output logic                out_valid,
    output logic [HALF_W-1:0]   result
);

    round_state_t      state_q, state_d;
    logic [XKEY_W-1:0] mixed_d, mixed_q;
    logic [HALF_W-1:0] box_word, perm_word;
    logic [HALF_W-1:0] result_q;
    logic              valid_q;

    keyswap_expand_mix u_mix (
        .half_in  (half_in),
        .swap_key (subkey[SUBKEY_W-1:XKEY_W]),
        .xor_key  (subkey[XKEY_W-1:0]),
        .mixed    (mixed_d)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_box
        keyswap_sbox #(.BOX(g)) u_box (
            .x (mixed_q[XKEY_W-1-g*GRP_W -: GRP_W]),
            .y (box_word[HALF_W-1-g*SB_W -: SB_W])
        );
    end

    keyswap_out_perm u_perm (
        .box_word  (box_word),
        .perm_word (perm_word)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_MIX;
            ST_MIX:  state_d = ST_EMIT;
            ST_EMIT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mixed_q  <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (state_q == ST_IDLE && start) mixed_q <= mixed_d;
            if (state_q == ST_MIX) begin
                result_q <= perm_word;
                valid_q  <= 1'b1;
            end
        end
    end

    assign out_valid = valid_q;
    assign result    = result_q;

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8
    valid_after_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state_q == ST_MIX));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(result));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q != ST_IDLE) |=> state_q != ST_MIX);

endmodule

// File: tb/keyswap_round_test.sv
`timescale 1ns/1ps
module keyswap_round_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] half_in = '0;
    logic [59:0] subkey = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    keyswap_round uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .half_in   (half_in),
        .subkey    (subkey),
        .out_valid (out_valid),
        .result    (result)
    );

    bit [7:0] t_off [4][4] = '{'{131,133,155,205}, '{204,167,173,65},
                               '{75,46,212,51},    '{234,205,46,4}};
    bit [8:0] t_mod [4][4] = '{'{333,313,505,369}, '{379,375,319,391},
                               '{361,445,451,397}, '{397,425,395,505}};

    function automatic bit [31:0] next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    // shift-and-add field product, reduced on every step
    function automatic bit [7:0] m_mul(bit [7:0] a, bit [7:0] b, bit [8:0] m);
        bit [8:0] acc = '0;
        bit [8:0] t = {1'b0, a};
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= t;
            t = t << 1;
            if (t[8]) t ^= m;
        end
        return acc[7:0];
    endfunction

    function automatic bit [31:0] model(bit [31:0] p, bit [59:0] k);
        bit [9:0] g [4];
        bit [9:0] tmp;
        bit [39:0] w;
        bit [31:0] y, r;
        g[0] = {p[1:0], p[31:24]};
        g[1] = p[25:16];
        g[2] = p[17:8];
        g[3] = p[9:0];
        for (int j = 0; j < 20; j++) begin
            if (k[40+j]) begin
                if (j % 2 == 1) begin
                    tmp[0] = g[0][j/2]; g[0][j/2] = g[2][j/2]; g[2][j/2] = tmp[0];
                end else begin
                    tmp[0] = g[1][j/2]; g[1][j/2] = g[3][j/2]; g[3][j/2] = tmp[0];
                end
            end
        end
        w = {g[0], g[1], g[2], g[3]} ^ k[39:0];
        for (int s = 0; s < 4; s++) begin
            bit [9:0] x = w[39-10*s -: 10];
            bit [1:0] row = {x[9], x[0]};
            bit [7:0] v = x[8:1] ^ t_off[s][row];
            bit [7:0] acc = 8'd1;
            for (int e = 0; e < 7; e++) acc = m_mul(acc, v, t_mod[s][row]);
            y[31-8*s -: 8] = acc;
        end
        for (int i = 0; i < 32; i++) r[(13*i + 7) % 32] = y[i];
        return r;
    endfunction

    task automatic check(string req, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one request; returns what is seen right after edge k+1
    task automatic run_op(bit [31:0] h, bit [59:0] k, output bit [31:0] res, output bit v);
        @(negedge clk);
        half_in = h; subkey = k; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
        #1;
        res = result; v = out_valid;
        @(posedge clk);
        #1;
    endtask

    function automatic bit [59:0] row_key(int row, bit [7:0] delta);
        bit [39:0] xk;
        for (int s = 0; s < 4; s++)
            xk[39-10*s -: 10] = {row[1], t_off[s][row] ^ delta, row[0]};
        return {20'h0, xk};
    endfunction

    task automatic t_reset();
        #1;
        check("R1 valid in reset", {31'b0, out_valid}, 32'd0);
        check("R1 result in reset", result, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 valid after reset", {31'b0, out_valid}, 32'd0);
        check("R1 result after reset", result, 32'd0);
    endtask

    task automatic t_hand_values();
        bit [31:0] r; bit v;
        run_op(32'h0, row_key(0, 8'd0), r, v);
        check("R6 zero base gives zero", r, 32'h0000_0000);
        run_op(32'h0, row_key(0, 8'd1), r, v);
        check("R6 unit base gives one", r, 32'h8080_8080);
        run_op(32'h0, row_key(0, 8'd2), r, v);
        check("R7 base two gives x^7", r, 32'h0404_0404);
    endtask

    task automatic t_rows();
        bit [31:0] r; bit v;
        for (int row = 0; row < 4; row++) begin
            run_op(32'h0, row_key(row, 8'd1), r, v);
            check($sformatf("R5 row %0d select", row), r, 32'h8080_8080);
        end
    endtask

    task automatic t_expand();
        bit [31:0] r; bit v;
        bit [31:0] pats [3] = '{32'h8000_0001, 32'h0F0F_F0F0, 32'hDEAD_BEEF};
        for (int i = 0; i < 3; i++) begin
            run_op(pats[i], 60'h0, r, v);
            check("R2 expansion", r, model(pats[i], 60'h0));
        end
    endtask

    task automatic t_swap();
        bit [31:0] r; bit v;
        bit [19:0] keys [4] = '{20'hAAAAA, 20'h55555, 20'hFFFFF, 20'h8_0001};
        for (int i = 0; i < 4; i++) begin
            bit [59:0] k = {keys[i], 40'h12_3456_789A};
            run_op(32'hC35A_1E87, k, r, v);
            check("R3 swap key", r, model(32'hC35A_1E87, k));
        end
    endtask

    task automatic t_subkey_split();
        bit [31:0] r; bit v;
        run_op(32'h0, {20'hFFFFF, 40'h0}, r, v);
        check("R4 swap key is not xor data", r, model(32'h0, 60'h0));
        run_op(32'h0, {20'h0, 40'hFF_0000_0000}, r, v);
        check("R4 xor key alignment", r, model(32'h0, {20'h0, 40'hFF_0000_0000}));
    endtask

    task automatic t_random();
        bit [31:0] r; bit v;
        for (int i = 0; i < 8; i++) begin
            bit [31:0] h = next_rand();
            bit [59:0] k = {next_rand(), next_rand()};
            run_op(h, k, r, v);
            check("R2 R3 R4 R5 R6 R7 random vector", r, model(h, k));
        end
    endtask

    task automatic t_timing();
        @(negedge clk);
        half_in = 32'h0; subkey = row_key(0, 8'd1); start = 1'b1;
        @(posedge clk); #1;
        check("R8 no valid after first edge", {31'b0, out_valid}, 32'd0);
        @(negedge clk); start = 1'b0;
        @(posedge clk); #1;
        check("R8 valid after second edge", {31'b0, out_valid}, 32'd1);
        check("R8 result with valid", result, 32'h8080_8080);
        @(posedge clk); #1;
        check("R8 valid drops", {31'b0, out_valid}, 32'd0);
        check("R8 result held", result, 32'h8080_8080);
    endtask

    task automatic t_busy();
        bit [59:0] ka = row_key(1, 8'd2);
        @(negedge clk);
        half_in = 32'h0; subkey = ka; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        half_in = 32'hFFFF_FFFF; subkey = {20'h12345, 40'hAB_CDEF_0123};
        @(posedge clk); #1;
        check("R9 first result kept", result, 32'h0404_0404);
        @(posedge clk); #1;
        @(negedge clk); start = 1'b0;
        @(posedge clk); #1;
        check("R9 no second pulse", {31'b0, out_valid}, 32'd0);
        check("R9 result unchanged", result, 32'h0404_0404);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_hand_values();
        t_rows();
        t_expand();
        t_swap();
        t_subkey_split();
        t_random();
        t_timing();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule